// File: doc/BRIEF.md
# Power Latch and Auto Self-Test Sequencer

This controller brings a maintenance display unit up automatically when the aircraft reports being on the ground. A rising edge on the OR of two air/ground discretes creates two independent one-cycle pulses. One pulse turns the power regulators on and runs a one-cycle supply check. The other pulse opens a timed automatic session. Power stays latched on only if the regulated logic supply is within limits at the check. A self-test failure or the end of the session drops the latch, and dropping the latch removes regulator power.

During the automatic session the block narrows the self-test enable mask to the two memory tests. It also passes two supply alarms to the processor: a hold request when the switched logic supply is low, and an interrupt when the unregulated rail sags. The session length is `TICKS` periods of a 1 Hz tick enable. The default of 180 gives three minutes.

Top module: `pwr_latch_seq`

## Requirements
- R1: After asynchronous reset `reg_en_o`, `latched_o`, `auto_on_o`, `hold_o` and `pwr_irq_o` are 0, and `test_en_o` is 7'h7F.
- R2: A 0-to-1 change of (`gnd_a_i` | `gnd_b_i`) sampled at a clock edge raises `reg_en_o` and `auto_on_o` at the second edge after it. A level held high, or a second input rising while the OR is already high, starts nothing new.
- R3: At the edge after `reg_en_o` rises (the check cycle), `latched_o` is set if `supply_ok_i` is 1. `latched_o` = 1 always implies `reg_en_o` = 1.
- R4: If `supply_ok_i` is 0 in the check cycle, `latched_o` stays 0 and `reg_en_o` returns to 0 at that edge. Nothing restarts until a new rising edge of the ground OR.
- R5: `test_en_o` is 7'b0000011 while `auto_on_o` is 1 (bit 0 = scratch-pad memory test, bit 1 = program memory test). Otherwise it is 7'h7F.
- R6: `test_fail_i` sampled high while latched clears `latched_o` and `reg_en_o` at that edge. It leaves `auto_on_o` unchanged. While the unit is not latched the strobe has no effect.
- R7: `auto_on_o` falls at the edge that samples the `TICKS`-th `tick_i` of the session. `latched_o` and `reg_en_o` fall one edge later.
- R8: A new ground rise during a session restarts the tick count from zero and leaves the latch undisturbed. When the restart pulse coincides with the final tick, the restart wins and the session does not end.
- R9: `hold_o` equals the inverse of `supply_ok_i` sampled at the previous edge.
- R10: `pwr_irq_o` equals `unreg_low_i` sampled at the previous edge.
- R11: `tick_i` has no effect while `auto_on_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, applied at first power |
| gnd_a_i | input | 1 | Air/ground discrete A, 1 = on ground |
| gnd_b_i | input | 1 | Air/ground discrete B, 1 = on ground |
| supply_ok_i | input | 1 | Regulated logic supply at or above 4.75 V |
| unreg_low_i | input | 1 | Unregulated 25 V rail below 18 V |
| test_fail_i | input | 1 | Self-test failure strobe from the processor |
| tick_i | input | 1 | One-cycle 1 Hz tick enable |
| reg_en_o | output | 1 | Power regulator enable |
| latched_o | output | 1 | Power latched on; self-tests may start |
| auto_on_o | output | 1 | Automatic session active |
| hold_o | output | 1 | Processor hold request |
| pwr_irq_o | output | 1 | Impending power-loss interrupt |
| test_en_o | output | 7 | Self-test enable mask |

## Verification
Two events can land on the same edge: the session-restart pulse from a fresh ground rise and the final tick that would end the session. The bench waits until TICKS-1 ticks have passed. It then raises the ground input one cycle before it drives the last tick, so that the registered restart pulse and the tick are sampled at the same edge. The restart is judged correct if `auto_on_o` and `latched_o` stay high and a full further TICKS ticks are then needed before the session ends.

// File: rtl/pls_pkg.sv
package pls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_LATCH = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/pls_edge_pulse.sv
module pls_edge_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gnd_a_i,
  input  logic gnd_b_i,
  output logic pwr_pulse_o,
  output logic auto_pulse_o
);
  logic gnd, gnd_q, rise;

  assign gnd  = gnd_a_i | gnd_b_i;
  assign rise = gnd & ~gnd_q;

  // two separate pulse circuits fed by one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnd_q        <= 1'b0;
      pwr_pulse_o  <= 1'b0;
      auto_pulse_o <= 1'b0;
    end else begin
      gnd_q        <= gnd;
      pwr_pulse_o  <= rise;
      auto_pulse_o <= rise;
    end
  end

  a_r2_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_pulse_o |=> !pwr_pulse_o);
  a_r2_pulse_needs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(auto_pulse_o) |-> $past(gnd_a_i | gnd_b_i));
endmodule

// File: rtl/pls_session_timer.sv
module pls_session_timer #(
  parameter int unsigned TICKS = 180
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic auto_on_o,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      auto_on_o <= 1'b0;
      expire_o  <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (start_i) begin
        // restart beats a coincident final tick
        cnt_q     <= '0;
        auto_on_o <= 1'b1;
      end else if (auto_on_o && tick_i) begin
        if (cnt_q == LAST) begin
          cnt_q     <= '0;
          auto_on_o <= 1'b0;
          expire_o  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  a_r7_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r11_idle_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_on_o && !start_i) |=> !auto_on_o);
  a_r8_restart_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (auto_on_o && !expire_o));
endmodule

// File: rtl/pls_latch_fsm.sv
module pls_latch_fsm
  import pls_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic supply_ok_i,
  input  logic test_fail_i,
  input  logic expire_i,
  output logic reg_en_o,
  output logic latched_o
);
  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_CHECK;
      ST_CHECK: begin
        if (expire_i || !supply_ok_i) state_d = ST_IDLE;
        else                          state_d = ST_LATCH;
      end
      ST_LATCH: if (test_fail_i || expire_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign reg_en_o  = (state_q != ST_IDLE);
  assign latched_o = (state_q == ST_LATCH);

  a_r3_rise_needs_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latched_o) |-> $past(supply_ok_i));
  a_r6_fail_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_o && test_fail_i) |=> (!latched_o && !reg_en_o));
  a_r4_bad_supply_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en_o && !latched_o && !supply_ok_i) |=> !reg_en_o);
endmodule

// File: rtl/pls_supply_mon.sv
module pls_supply_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic unreg_low_i,
  output logic hold_o,
  output logic pwr_irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o    <= 1'b0;
      pwr_irq_o <= 1'b0;
    end else begin
      hold_o    <= ~supply_ok_i;
      pwr_irq_o <= unreg_low_i;
    end
  end

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> hold_o);
  a_r10_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unreg_low_i |=> pwr_irq_o);
endmodule

// File: rtl/pwr_latch_seq.sv
module pwr_latch_seq #(
  parameter int unsigned TICKS     = 180,
  parameter int unsigned N_TESTS   = 7,
  parameter logic [N_TESTS-1:0] AUTO_MASK = N_TESTS'(2'b11)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               gnd_a_i,
  input  logic               gnd_b_i,
  input  logic               supply_ok_i,
  input  logic               unreg_low_i,
  input  logic               test_fail_i,
  input  logic               tick_i,
  output logic               reg_en_o,
  output logic               latched_o,
  output logic               auto_on_o,
  output logic               hold_o,
  output logic               pwr_irq_o,
  output logic [N_TESTS-1:0] test_en_o
);
  localparam logic [N_TESTS-1:0] ALL_MASK = '1;

  logic pwr_pulse, auto_pulse, expire;

  pls_edge_pulse u_edge (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .gnd_a_i      (gnd_a_i),
    .gnd_b_i      (gnd_b_i),
    .pwr_pulse_o  (pwr_pulse),
    .auto_pulse_o (auto_pulse)
  );

  pls_session_timer #(.TICKS(TICKS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (auto_pulse),
    .tick_i    (tick_i),
    .auto_on_o (auto_on_o),
    .expire_o  (expire)
  );

  pls_latch_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (pwr_pulse),
    .supply_ok_i (supply_ok_i),
    .test_fail_i (test_fail_i),
    .expire_i    (expire),
    .reg_en_o    (reg_en_o),
    .latched_o   (latched_o)
  );

  pls_supply_mon u_mon (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .unreg_low_i (unreg_low_i),
    .hold_o      (hold_o),
    .pwr_irq_o   (pwr_irq_o)
  );

  assign test_en_o = auto_on_o ? AUTO_MASK : ALL_MASK;

  a_r3_latch_needs_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_o |-> reg_en_o);
  a_r7_expiry_drops_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(auto_on_o) |=> !latched_o);
endmodule

// File: tb/pwr_latch_seq_tb_top.sv
module pwr_latch_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TK = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnd_a = 1'b0, gnd_b = 1'b0, sup_ok = 1'b1, unreg_low = 1'b0;
  logic fail = 1'b0, tick = 1'b0;
  logic reg_en, latched, auto_on, hold, irq;
  logic [6:0] test_en;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_latch_seq #(.TICKS(TK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .gnd_a_i(gnd_a), .gnd_b_i(gnd_b),
    .supply_ok_i(sup_ok), .unreg_low_i(unreg_low), .test_fail_i(fail),
    .tick_i(tick), .reg_en_o(reg_en), .latched_o(latched),
    .auto_on_o(auto_on), .hold_o(hold), .pwr_irq_o(irq), .test_en_o(test_en)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; nclk(1); tick = 1'b0; nclk(1);
    end
  endtask

  task automatic t_reset;
    chk("R1 reg_en", reg_en, 0);
    chk("R1 latched", latched, 0);
    chk("R1 auto_on", auto_on, 0);
    chk("R1 hold", hold, 0);
    chk("R1 irq", irq, 0);
    chk("R1 test_en", test_en, 7'h7F);
  endtask

  task automatic t_start_ok;
    gnd_b = 1'b1; nclk(1);
    chk("R2 no reg_en yet", reg_en, 0);
    nclk(1);
    chk("R2 reg_en", reg_en, 1);
    chk("R2 auto_on", auto_on, 1);
    chk("R3 not yet latched", latched, 0);
    chk("R5 auto mask", test_en, 7'b0000011);
    gnd_a = 1'b1;
    nclk(1);
    chk("R3 latched", latched, 1);
    nclk(3);
    chk("R2 held level no restart", latched, 1);
    gnd_a = 1'b0; gnd_b = 1'b0; nclk(1);
  endtask

  task automatic t_expire;
    tick_n(TK - 1);
    chk("R7 still auto", auto_on, 1);
    tick = 1'b1; nclk(1); tick = 1'b0;
    chk("R7 auto dropped", auto_on, 0);
    chk("R7 latch one more cycle", latched, 1);
    nclk(1);
    chk("R7 latch cleared", latched, 0);
    chk("R7 reg_en cleared", reg_en, 0);
    chk("R5 manual mask", test_en, 7'h7F);
  endtask

  task automatic t_idle_ticks;
    tick_n(3);
    chk("R11 idle ticks", auto_on, 0);
    chk("R11 idle reg_en", reg_en, 0);
  endtask

  task automatic t_fail_strobe;
    t_start_ok();
    tick_n(2);
    fail = 1'b1; nclk(1); fail = 1'b0;
    chk("R6 latch cleared", latched, 0);
    chk("R6 reg_en cleared", reg_en, 0);
    chk("R6 auto kept", auto_on, 1);
    fail = 1'b1; nclk(1); fail = 1'b0; nclk(1);
    chk("R6 idle fail ignored", reg_en, 0);
    tick_n(TK - 2);
    chk("R7 session ends after fail", auto_on, 0);
  endtask

  task automatic t_check_fail;
    sup_ok = 1'b0;
    gnd_a = 1'b1; nclk(2);
    chk("R4 reg_en pulses", reg_en, 1);
    nclk(1);
    chk("R4 reg_en dropped", reg_en, 0);
    chk("R4 no latch", latched, 0);
    chk("R9 hold on low supply", hold, 1);
    sup_ok = 1'b1; nclk(3);
    chk("R4 no relaunch", reg_en, 0);
    chk("R9 hold released", hold, 0);
    gnd_a = 1'b0; nclk(1);
    tick_n(TK);
    chk("R4 session ended", auto_on, 0);
  endtask

  task automatic t_collision;
    t_start_ok();
    tick_n(TK - 1);
    gnd_a = 1'b1; nclk(1);
    tick = 1'b1; nclk(1); tick = 1'b0;
    chk("R8 restart wins auto", auto_on, 1);
    chk("R8 latch undisturbed", latched, 1);
    gnd_a = 1'b0; nclk(1);
    tick_n(TK - 1);
    chk("R8 count restarted", auto_on, 1);
    tick = 1'b1; nclk(1); tick = 1'b0;
    chk("R8 ends after full count", auto_on, 0);
    nclk(1);
    chk("R8 latch cleared", latched, 0);
  endtask

  task automatic t_irq;
    unreg_low = 1'b1; nclk(1);
    chk("R10 irq raised", irq, 1);
    unreg_low = 1'b0; nclk(1);
    chk("R10 irq cleared", irq, 0);
  endtask

  initial begin
    nclk(2);
    t_reset();
    rst_n = 1'b1; nclk(1);
    t_reset();
    t_start_ok();
    t_expire();
    t_idle_ticks();
    t_fail_strobe();
    t_check_fail();
    t_collision();
    t_irq();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule